// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Centre-of-Stop Rearm

This block receives 8-bit characters from an asynchronous serial line, such as the receive pin of a differential line transceiver on a shared test bus. A free-running tick at sixteen times the bit rate paces it. The raw line first passes through a chain of flip-flops. After that, the receiver looks for the falling edge of a start bit. It confirms the start bit half a bit later and then reads every data bit and the stop bit at its estimated centre. Each completed character is presented on a byte output together with a one-cycle valid strobe. A stop bit that reads low produces a one-cycle framing-error strobe instead.

The receiver does not wait for the end of the stop bit. Once the stop bit has been read high at its centre, it returns at once to hunting for the next start edge. Each character then takes its bit timing from its own start edge, so timing error does not build up over a stream of characters. Characters that follow each other with no gap are received even when the sender's bit rate is a few percent faster or slower than the receiver's.

Top module: `uart_rx_rearm`

## Requirements
- R1: While reset is low at a clock edge, and after its release, rx_valid and rx_frame_err are low and rx_data is 0. A reset applied in the middle of a character discards that character, and the next complete character is received normally.
- R2: A frame is one start bit (low), then 8 data bits with the least significant bit first, then one stop bit (high). On such a frame, rx_data holds the 8 data bits in their original order when rx_valid is high.
- R3: rx_valid is high for exactly one clock cycle per received character. It rises in the cycle after the tick on which the stop bit is sampled.
- R4: The receiver begins hunting for the next start edge right after the centre sample of the stop bit. A stop bit that lasts only about 0.7 of a bit period, followed immediately by the next start bit, still lets both characters be received.
- R5: A low pulse that has ended before the eighth tick after it was detected is treated as a glitch. It produces neither rx_valid nor rx_frame_err, and the next real character is received correctly.
- R6: A stop bit sampled low causes a one-cycle pulse on rx_frame_err, produces no rx_valid, and leaves rx_data at its previous value.
- R7: After a framing error, no new character starts while the line stays low. Reception resumes with the first falling edge after the line has returned high.
- R8: Characters sent back to back with a bit period about 3% shorter or 3% longer than the receiver's nominal period are all received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Raw asynchronous serial input; idles high |
| sample_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_data | output | 8 | Last byte that was received correctly |
| rx_valid | output | 1 | One-cycle strobe that marks a new rx_data |
| rx_frame_err | output | 1 | One-cycle strobe when a stop bit reads low |

## Verification
The hardest case to reach is a start edge that arrives while the stop bit of the previous character is still on the line, before a receiver that waits for the end of the stop bit would be listening again. The stimulus creates it in two ways. First, it shortens the stop bit to about 0.7 of a period and starts the next character right after it. Second, it streams characters back to back from a sender that runs about 3% fast, so that each start edge lands earlier than the nominal stop-bit end. In both cases every byte must be reported, in order.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the asynchronous byte receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    // Receiver sequencing states
    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,   // watching for a falling start edge
        ST_START = 3'd1,   // confirming the start bit at its centre
        ST_DATA  = 3'd2,   // sampling data bits
        ST_STOP  = 3'd3,   // sampling the stop bit
        ST_BREAK = 3'd4    // after a framing error, waiting for the line to go high
    } rx_state_t;

endpackage

// File: rtl/rx_sync.sv
// Module: rx_sync
// Passes an asynchronous single-bit input through a chain of flip-flops
// before any logic uses it. Assumes STAGES >= 2. Resets to the idle-high level.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/rx_shift.sv
// Module: rx_shift
// Collects serial data bits with the least significant bit first and
// copies the assembled word to the output register when a load is requested.
// Assumes shift_en and load_en are never high in the same cycle.
module rx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             load_en,
    output logic [WIDTH-1:0] word_out
);

    logic [WIDTH-1:0] shreg;

    // Shift right, new bit entering at the top, so the first bit ends at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {bit_in, shreg[WIDTH-1:1]};
    end

    // Hold the last good word until the next accepted character
    always_ff @(posedge clk) begin
        if (!rst_n)       word_out <= '0;
        else if (load_en) word_out <= shreg;
    end

endmodule

// File: rtl/uart_rx_rearm.sv
// Module: uart_rx_rearm
// Asynchronous serial receiver, 8N1 by default. It synchronizes the line,
// hunts for a start edge, confirms it at half a bit, samples data and stop
// at the bit centres, and returns to hunting as soon as the stop-bit centre
// has been sampled high. Assumes sample_tick pulses for one clock at
// OVERSAMPLE times the bit rate and that OVERSAMPLE is even.
module uart_rx_rearm
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 sample_tick,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_BITS - 1);

    rx_state_t        state;
    logic [CNT_W-1:0] tick_cnt;
    logic [BIT_W-1:0] bit_idx;
    logic             line_s;
    logic             centre_hit;
    logic             shift_en;
    logic             load_en;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_line),
        .sync_out (line_s)
    );

    // Decode a full-bit centre sample and the datapath strobes it drives
    always_comb begin
        centre_hit = sample_tick && (tick_cnt == FULL_LAST);
        shift_en   = centre_hit && (state == ST_DATA);
        load_en    = centre_hit && (state == ST_STOP) && line_s;
    end

    rx_shift #(.WIDTH(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (line_s),
        .load_en  (load_en),
        .word_out (rx_data)
    );

    // Sequence the frame: hunt, confirm start, data bits, stop, break recovery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_HUNT;
            tick_cnt     <= '0;
            bit_idx      <= '0;
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
        end else begin
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
            if (sample_tick) begin
                case (state)
                    ST_HUNT: begin
                        if (!line_s) begin
                            state    <= ST_START;
                            tick_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (tick_cnt == HALF_LAST) begin
                            tick_cnt <= '0;
                            bit_idx  <= '0;
                            state    <= line_s ? ST_HUNT : ST_DATA;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (tick_cnt == FULL_LAST) begin
                            tick_cnt <= '0;
                            bit_idx  <= bit_idx + 1'b1;
                            if (bit_idx == LAST_BIT) state <= ST_STOP;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tick_cnt == FULL_LAST) begin
                            tick_cnt <= '0;
                            if (line_s) begin
                                rx_valid <= 1'b1;
                                state    <= ST_HUNT;
                            end else begin
                                rx_frame_err <= 1'b1;
                                state        <= ST_BREAK;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_BREAK: begin
                        if (line_s) state <= ST_HUNT;
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // Assertions guarding the strobes and the rearm point
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                   // R3
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sample_tick));                          // R3
    AST_REARM_AT_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state == ST_HUNT));                          // R4
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> !rx_frame_err);                           // R6
    AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_frame_err));                              // R6
    AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> $stable(rx_data));                        // R6
    AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK && !line_s) |=> (state == ST_BREAK));   // R7
    AST_GLITCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && sample_tick && tick_cnt == HALF_LAST && line_s)
        |=> (state == ST_HUNT));                                   // R5

endmodule

// File: tb/uart_rx_rearm_bench.sv
// Bench for uart_rx_rearm: a table of back-to-back characters at three bit
// periods, then directed tests for reset, short stop bits, glitches,
// framing errors and break recovery.
module uart_rx_rearm_bench;

    localparam int NOM = 64;          // clocks per bit: 16 ticks of 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       sample_tick = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] log_data [0:63];
    int  n_valid = 0;
    int  n_err   = 0;
    int  n_long  = 0;
    bit  prev_valid = 1'b0;
    bit  prev_err = 1'b0;

    // {byte, bit period in clocks}
    localparam logic [15:0] VEC [8] = '{
        {8'h55, 8'd64}, {8'hA3, 8'd64}, {8'h00, 8'd64}, {8'hFF, 8'd64},
        {8'h81, 8'd62}, {8'h3C, 8'd62}, {8'h7E, 8'd66}, {8'hC5, 8'd66}
    };

    always #2.5 clk = ~clk;

    uart_rx_rearm u_uart_rx_rearm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_line      (rx_line),
        .sample_tick  (sample_tick),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

    // Tick every fourth clock, driven away from the active edge
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        sample_tick = (tdiv == 0);
    end

    // Record strobes and pulse lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (n_valid < 64) log_data[n_valid] = rx_data;
                n_valid++;
                if (prev_valid) n_long++;
            end
            if (rx_frame_err) begin
                n_err++;
                if (prev_err) n_long++;
            end
        end
        prev_valid = rx_valid;
        prev_err   = rx_frame_err;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int per, input int stop_len,
                        input logic stop_val);
        hold(1'b0, per);
        for (int i = 0; i < 8; i++) hold(b[i], per);
        hold(stop_val, stop_len);
    endtask

    task automatic clear_log();
        n_valid = 0;
        n_err   = 0;
        n_long  = 0;
    endtask

    // Watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        check(!rx_valid && !rx_frame_err && rx_data == 8'h00, "R1 reset",
              {rx_valid, rx_frame_err, rx_data}, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(n_valid == 0 && n_err == 0 && rx_data == 8'h00, "R1 idle after reset",
              n_valid + n_err, 0);

        // R2 R8: table of back-to-back characters at nominal, fast, slow periods
        clear_log();
        foreach (VEC[i]) send(VEC[i][15:8], int'(VEC[i][7:0]), int'(VEC[i][7:0]), 1'b1);
        hold(1'b1, 3 * NOM);
        check(n_valid == 8, "R8 count back-to-back", n_valid, 8);
        for (int i = 0; i < 8; i++)
            check(log_data[i] == VEC[i][15:8], (i < 4) ? "R2 byte" : "R8 byte",
                  log_data[i], VEC[i][15:8]);
        check(n_err == 0, "R2 no framing error", n_err, 0);
        check(n_long == 0, "R3 strobe width", n_long, 0);

        // R4: stop bit of ~0.7 bit followed at once by the next start
        clear_log();
        send(8'h96, NOM, 44, 1'b1);
        send(8'h2B, NOM, 44, 1'b1);
        send(8'hE1, NOM, NOM, 1'b1);
        hold(1'b1, 2 * NOM);
        check(n_valid == 3, "R4 short stop count", n_valid, 3);
        check(log_data[0] == 8'h96, "R4 first", log_data[0], 8'h96);
        check(log_data[1] == 8'h2B, "R4 second", log_data[1], 8'h2B);
        check(log_data[2] == 8'hE1, "R4 third", log_data[2], 8'hE1);

        // R5: glitch of four ticks is ignored
        clear_log();
        hold(1'b0, 16);
        hold(1'b1, 2 * NOM);
        check(n_valid == 0 && n_err == 0, "R5 glitch ignored", n_valid + n_err, 0);
        send(8'h5A, NOM, NOM, 1'b1);
        hold(1'b1, NOM);
        check(n_valid == 1 && log_data[0] == 8'h5A, "R5 next byte",
              log_data[0], 8'h5A);

        // R6: low stop bit; R7: line held low afterwards
        clear_log();
        send(8'h33, NOM, 4 * NOM, 1'b0);
        check(n_err == 1, "R6 framing error", n_err, 1);
        check(n_valid == 0, "R6 no valid", n_valid, 0);
        check(rx_data == 8'h5A, "R6 data kept", rx_data, 8'h5A);
        check(n_long == 0, "R6 error strobe width", n_long, 0);
        check(n_err == 1 && n_valid == 0, "R7 no start during break",
              n_err + n_valid, 1);
        hold(1'b1, NOM);
        send(8'hC3, NOM, NOM, 1'b1);
        hold(1'b1, NOM);
        check(n_valid == 1 && log_data[0] == 8'hC3, "R7 recovery",
              log_data[0], 8'hC3);

        // R1: reset in the middle of a character
        clear_log();
        hold(1'b0, NOM);
        hold(1'b1, 2 * NOM);
        rx_line = 1'b0;
        repeat (NOM) @(negedge clk);
        rst_n = 1'b0;
        rx_line = 1'b1;
        repeat (3) @(negedge clk);
        check(!rx_valid && !rx_frame_err && rx_data == 8'h00, "R1 mid-frame reset",
              rx_data, 0);
        rst_n = 1'b1;
        hold(1'b1, 2 * NOM);
        clear_log();
        send(8'h69, NOM, NOM, 1'b1);
        hold(1'b1, NOM);
        check(n_valid == 1 && log_data[0] == 8'h69 && n_err == 0,
              "R1 receive after reset", log_data[0], 8'h69);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule